// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This unit sits between a UART's register file, its receive FIFO and its external modem and receive paths. It provides the internal loopback mode. Loopback is switched on and off through the loopback-enable bit carried by each control-register write. While loopback is on, the four software-driven modem outputs drive the four modem status flags back to software. The transmitted data bytes and raised break conditions go straight into the receive FIFO. External receive characters and external break events are dropped.

While loopback is off, the modem status flags track the external modem pins through a configurable synchroniser. External receive characters and external break events feed the receive FIFO. Every control write made with loopback enabled also asks the interrupt logic to rebuild the modem-status interrupt bits. For that it gives a one-cycle rebuild strobe and the four new bit values. The interrupt logic clears all four bits and then sets the ones that are marked.

The FIFO push port takes one word per cycle. The word holds a break marker above the data byte. When a data byte and a break arrive in the same cycle, the data byte goes first and the break is held until the next cycle that has no data.

Top module: `uart_loopback_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four status flags are 0, `fifo_push` is 0, `ms_rebuild` is 0 and loopback is off.
- R2: With loopback off, each status flag equals its external pin. A pin change is visible PIN_SYNC+1 clock edges after it is applied.
- R3: On the edge where `ctrl_wr` is high and `ctrl_loop_en` is 1, the flags take the control values. Ring indicator comes from out2, carrier detect from out1, clear-to-send from rts and data-set-ready from dtr. This includes the write that first turns loopback on, and the flags are visible one cycle later.
- R4: That same write makes `ms_rebuild` high for exactly one cycle, in the same cycle as the flags. `ms_set` carries the looped flags with bit 0 = ring indicator, bit 1 = clear-to-send, bit 2 = carrier detect and bit 3 = data-set-ready.
- R5: A control write with `ctrl_loop_en` = 0 gives no rebuild strobe. With loopback on and no write, the flags hold their value whatever the pins do.
- R6: With loopback on, a byte with `tx_valid` high is pushed one cycle later as a word with bit DATA_W = 0 (break marker) and the byte in bits DATA_W-1:0.
- R7: With loopback on, a 0-to-1 change of `send_brk` pushes one break word: bit DATA_W = 1 and data bits 0. A level that stays at 1, or a 1-to-0 change, pushes nothing.
- R8: With loopback on, `ext_rx_valid` and `ext_brk` push nothing.
- R9: With loopback off, an external byte is pushed one cycle later and an external break pushes a break word. Transmitted bytes and `send_brk` rises push nothing.
- R10: When a data byte and a break event occur in the same cycle, the data word is pushed first. The break word follows in the first later cycle without data. Break events that occur while a break is still pending merge into that single break word.
- R11: The loopback setting taken in on a control write steers the data paths from the following cycle. Input bytes in the write cycle itself follow the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_loop_en | input | 1 | Loopback enable value of the write |
| ctrl_out2 | input | 1 | Software modem output 2 |
| ctrl_out1 | input | 1 | Software modem output 1 |
| ctrl_rts | input | 1 | Software request-to-send output |
| ctrl_dtr | input | 1 | Software data-terminal-ready output |
| send_brk | input | 1 | Line-control send-break level |
| tx_valid | input | 1 | Transmit byte strobe |
| tx_data | input | DATA_W | Transmit byte |
| ext_rx_valid | input | 1 | External receive byte strobe |
| ext_rx_data | input | DATA_W | External receive byte |
| ext_brk | input | 1 | External break detected (pulse) |
| pin_ri | input | 1 | External ring indicator pin |
| pin_dcd | input | 1 | External carrier detect pin |
| pin_cts | input | 1 | External clear-to-send pin |
| pin_dsr | input | 1 | External data-set-ready pin |
| fifo_push | output | 1 | Receive FIFO push strobe |
| fifo_word | output | DATA_W+1 | Pushed word: break marker at bit DATA_W, data below |
| sts_ri | output | 1 | Ring indicator status flag |
| sts_dcd | output | 1 | Carrier detect status flag |
| sts_cts | output | 1 | Clear-to-send status flag |
| sts_dsr | output | 1 | Data-set-ready status flag |
| ms_rebuild | output | 1 | Clear-then-set strobe for modem interrupt bits |
| ms_set | output | 4 | Modem interrupt bits to set on rebuild |

## Verification
Two functions can fall in the same cycle: pushing a data byte and pushing a break word. With loopback on, the bench provokes this by raising `send_brk` in the cycle where `tx_valid` is high. With loopback off, it asserts `ext_brk` together with `ext_rx_valid`. It also repeats the collision over consecutive data cycles to show that the pending break merges. The bench judges the result from the push sequence it observes: each data word must appear exactly one cycle after its byte, and exactly one break word must follow in the first idle cycle, with nothing after it.

// File: rtl/uartlb_pkg.sv
package uartlb_pkg;
   localparam int MS_N   = 4;
   localparam int MS_RI  = 0;
   localparam int MS_CTS = 1;
   localparam int MS_DCD = 2;
   localparam int MS_DSR = 3;

   typedef logic [MS_N-1:0] ms_vec_t;
endpackage

// File: rtl/uartlb_modem.sv
module uartlb_modem
   import uartlb_pkg::*;
#(
   parameter int PIN_SYNC = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    ctrl_wr,
   input  logic    ctrl_loop_en,
   input  ms_vec_t ctrl_ms,
   input  ms_vec_t pins,
   output logic    loop_q,
   output ms_vec_t sts_q,
   output logic    rebuild_q,
   output ms_vec_t set_q
);
   ms_vec_t pins_s;

   generate
      if (PIN_SYNC == 0) begin : g_nosync
         assign pins_s = pins;
      end else begin : g_sync
         ms_vec_t sync_q [PIN_SYNC];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < PIN_SYNC; i++) sync_q[i] <= '0;
            end else begin
               sync_q[0] <= pins;
               for (int i = 1; i < PIN_SYNC; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign pins_s = sync_q[PIN_SYNC-1];
      end
   endgenerate

   logic    loop_wr;
   ms_vec_t sts_d;

   assign loop_wr = ctrl_wr & ctrl_loop_en;

   always_comb begin
      if (loop_wr)     sts_d = ctrl_ms;
      else if (ctrl_wr) sts_d = pins_s;
      else if (loop_q) sts_d = sts_q;
      else             sts_d = pins_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loop_q    <= 1'b0;
         sts_q     <= '0;
         rebuild_q <= 1'b0;
         set_q     <= '0;
      end else begin
         if (ctrl_wr) loop_q <= ctrl_loop_en;
         sts_q     <= sts_d;
         rebuild_q <= loop_wr;
         set_q     <= loop_wr ? ctrl_ms : '0;
      end
   end
endmodule

// File: rtl/uartlb_brk.sv
module uartlb_brk (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_q,
   input  logic send_brk,
   input  logic ext_brk,
   output logic brk_evt
);
   logic brk_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) brk_prev_q <= 1'b0;
      else        brk_prev_q <= send_brk;
   end

   assign brk_evt = loop_q ? (send_brk & ~brk_prev_q) : ext_brk;
endmodule

// File: rtl/uartlb_push.sv
module uartlb_push #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop_q,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              brk_evt,
   output logic              push_q,
   output logic [DATA_W:0]   word_q
);
   localparam int WORD_W = DATA_W + 1;

   logic              pend_q;
   logic              data_v;
   logic [DATA_W-1:0] data_sel;
   logic              pend_any;
   logic [WORD_W-1:0] word_d;

   assign data_v   = loop_q ? tx_valid : rx_valid;
   assign data_sel = loop_q ? tx_data  : rx_data;
   assign pend_any = pend_q | brk_evt;
   assign word_d   = data_v ? {1'b0, data_sel} : {1'b1, {DATA_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         push_q <= 1'b0;
         word_q <= '0;
      end else begin
         pend_q <= data_v & pend_any;
         push_q <= data_v | pend_any;
         word_q <= (data_v | pend_any) ? word_d : '0;
      end
   end
endmodule

// File: rtl/uart_loopback_unit.sv
module uart_loopback_unit
   import uartlb_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PIN_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              ctrl_loop_en,
   input  logic              ctrl_out2,
   input  logic              ctrl_out1,
   input  logic              ctrl_rts,
   input  logic              ctrl_dtr,
   input  logic              send_brk,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              ext_rx_valid,
   input  logic [DATA_W-1:0] ext_rx_data,
   input  logic              ext_brk,
   input  logic              pin_ri,
   input  logic              pin_dcd,
   input  logic              pin_cts,
   input  logic              pin_dsr,
   output logic              fifo_push,
   output logic [DATA_W:0]   fifo_word,
   output logic              sts_ri,
   output logic              sts_dcd,
   output logic              sts_cts,
   output logic              sts_dsr,
   output logic              ms_rebuild,
   output logic [3:0]        ms_set
);
   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("uart_loopback_unit: DATA_W must lie in 5..16");
      end
      if (PIN_SYNC < 0 || PIN_SYNC > 3) begin : g_bad_sync
         $error("uart_loopback_unit: PIN_SYNC must lie in 0..3");
      end
   endgenerate

   ms_vec_t ctrl_ms;
   ms_vec_t pins;
   ms_vec_t sts_q;
   ms_vec_t set_q;
   logic    loop_q;
   logic    brk_evt;

   always_comb begin
      ctrl_ms         = '0;
      ctrl_ms[MS_RI]  = ctrl_out2;
      ctrl_ms[MS_DCD] = ctrl_out1;
      ctrl_ms[MS_CTS] = ctrl_rts;
      ctrl_ms[MS_DSR] = ctrl_dtr;
      pins            = '0;
      pins[MS_RI]     = pin_ri;
      pins[MS_DCD]    = pin_dcd;
      pins[MS_CTS]    = pin_cts;
      pins[MS_DSR]    = pin_dsr;
   end

   uartlb_modem #(.PIN_SYNC(PIN_SYNC)) u_modem (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr      (ctrl_wr),
      .ctrl_loop_en (ctrl_loop_en),
      .ctrl_ms      (ctrl_ms),
      .pins         (pins),
      .loop_q       (loop_q),
      .sts_q        (sts_q),
      .rebuild_q    (ms_rebuild),
      .set_q        (set_q)
   );

   uartlb_brk u_brk (
      .clk      (clk),
      .rst_n    (rst_n),
      .loop_q   (loop_q),
      .send_brk (send_brk),
      .ext_brk  (ext_brk),
      .brk_evt  (brk_evt)
   );

   uartlb_push #(.DATA_W(DATA_W)) u_push (
      .clk      (clk),
      .rst_n    (rst_n),
      .loop_q   (loop_q),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .rx_valid (ext_rx_valid),
      .rx_data  (ext_rx_data),
      .brk_evt  (brk_evt),
      .push_q   (fifo_push),
      .word_q   (fifo_word)
   );

   assign sts_ri  = sts_q[MS_RI];
   assign sts_dcd = sts_q[MS_DCD];
   assign sts_cts = sts_q[MS_CTS];
   assign sts_dsr = sts_q[MS_DSR];
   assign ms_set  = set_q;
endmodule

// File: rtl/uart_loopback_unit_chk.sv
module uart_loopback_unit_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr,
   input logic              ctrl_loop_en,
   input logic              ctrl_out2,
   input logic              ctrl_out1,
   input logic              ctrl_rts,
   input logic              ctrl_dtr,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              ext_rx_valid,
   input logic [DATA_W-1:0] ext_rx_data,
   input logic              loop_q,
   input logic              fifo_push,
   input logic [DATA_W:0]   fifo_word,
   input logic              sts_ri,
   input logic              sts_dcd,
   input logic              sts_cts,
   input logic              sts_dsr,
   input logic              ms_rebuild,
   input logic [3:0]        ms_set
);
   assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_loop_en) |=> (sts_ri == $past(ctrl_out2) && sts_dcd == $past(ctrl_out1)
                                     && sts_cts == $past(ctrl_rts) && sts_dsr == $past(ctrl_dtr)));

   assert_rebuild_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_loop_en) |=> (ms_rebuild && ms_set == {sts_dsr, sts_dcd, sts_cts, sts_ri}));

   assert_no_rebuild_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_wr && ctrl_loop_en) |=> !ms_rebuild);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_q && !ctrl_wr) |=> $stable({sts_ri, sts_dcd, sts_cts, sts_dsr}));

   assert_tx_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_q && tx_valid) |=> (fifo_push && fifo_word == {1'b0, $past(tx_data)}));

   assert_rx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_q && ext_rx_valid) |=> (fifo_push && fifo_word == {1'b0, $past(ext_rx_data)}));

   assert_brk_after_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && fifo_word[DATA_W]) |-> !$past(loop_q ? tx_valid : ext_rx_valid));
endmodule

bind uart_loopback_unit uart_loopback_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctrl_wr      (ctrl_wr),
   .ctrl_loop_en (ctrl_loop_en),
   .ctrl_out2    (ctrl_out2),
   .ctrl_out1    (ctrl_out1),
   .ctrl_rts     (ctrl_rts),
   .ctrl_dtr     (ctrl_dtr),
   .tx_valid     (tx_valid),
   .tx_data      (tx_data),
   .ext_rx_valid (ext_rx_valid),
   .ext_rx_data  (ext_rx_data),
   .loop_q       (loop_q),
   .fifo_push    (fifo_push),
   .fifo_word    (fifo_word),
   .sts_ri       (sts_ri),
   .sts_dcd      (sts_dcd),
   .sts_cts      (sts_cts),
   .sts_dsr      (sts_dsr),
   .ms_rebuild   (ms_rebuild),
   .ms_set       (ms_set)
);

// File: tb/uart_loopback_unit_bench.sv
module uart_loopback_unit_bench;
   localparam int DW   = 8;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctrl_wr = 0, ctrl_loop_en = 0, ctrl_out2 = 0, ctrl_out1 = 0, ctrl_rts = 0, ctrl_dtr = 0;
   logic send_brk = 0, tx_valid = 0, ext_rx_valid = 0, ext_brk = 0;
   logic [DW-1:0] tx_data = '0, ext_rx_data = '0;
   logic pin_ri = 0, pin_dcd = 0, pin_cts = 0, pin_dsr = 0;
   logic fifo_push;
   logic [DW:0] fifo_word;
   logic sts_ri, sts_dcd, sts_cts, sts_dsr, ms_rebuild;
   logic [3:0] ms_set;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   uart_loopback_unit #(.DATA_W(DW), .PIN_SYNC(SYNC)) u_uart_loopback_unit (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_loop_en(ctrl_loop_en),
      .ctrl_out2(ctrl_out2), .ctrl_out1(ctrl_out1), .ctrl_rts(ctrl_rts), .ctrl_dtr(ctrl_dtr),
      .send_brk(send_brk), .tx_valid(tx_valid), .tx_data(tx_data),
      .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_brk(ext_brk),
      .pin_ri(pin_ri), .pin_dcd(pin_dcd), .pin_cts(pin_cts), .pin_dsr(pin_dsr),
      .fifo_push(fifo_push), .fifo_word(fifo_word),
      .sts_ri(sts_ri), .sts_dcd(sts_dcd), .sts_cts(sts_cts), .sts_dsr(sts_dsr),
      .ms_rebuild(ms_rebuild), .ms_set(ms_set)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // status as {dsr,dcd,cts,ri}, same order as ms_set
   function automatic logic [3:0] sts();
      return {sts_dsr, sts_dcd, sts_cts, sts_ri};
   endfunction

   task automatic ctrl_write(input logic loop, input logic [3:0] v);
      ctrl_wr = 1; ctrl_loop_en = loop;
      ctrl_out2 = v[0]; ctrl_out1 = v[1]; ctrl_rts = v[2]; ctrl_dtr = v[3];
      step();
      ctrl_wr = 0;
   endtask

   task automatic set_pins(input logic [3:0] p);
      pin_ri = p[0]; pin_cts = p[1]; pin_dcd = p[2]; pin_dsr = p[3];
   endtask

   task automatic chk_push(input string req, input logic exp_push, input logic [DW:0] exp_word);
      chk(req, {31'd0, fifo_push}, {31'd0, exp_push});
      if (exp_push) chk(req, {23'd0, fifo_word}, {23'd0, exp_word});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      repeat (3) step();
      // R1: reset state
      chk("R1 sts", {28'd0, sts()}, 32'd0);
      chk("R1 push", {31'd0, fifo_push}, 32'd0);
      chk("R1 rebuild", {31'd0, ms_rebuild}, 32'd0);
      rst_n = 1;
      step();
      chk("R1 after release", {26'd0, sts(), fifo_push, ms_rebuild}, 32'd0);

      // R2: pins followed with loopback off, full sweep
      for (int p = 0; p < 16; p++) begin
         set_pins(p[3:0]);
         repeat (SYNC + 1) step();
         chk("R2 pin follow", {28'd0, sts()}, p);
      end

      // R9: loopback off data paths
      tx_valid = 1; tx_data = 8'h3C; step(); tx_valid = 0;
      chk_push("R9 tx ignored when off", 1'b0, '0);
      send_brk = 1; step(); chk_push("R9 brk rise ignored when off", 1'b0, '0);
      send_brk = 0; step();
      for (int d = 0; d < 256; d += 37) begin
         ext_rx_valid = 1; ext_rx_data = d[7:0]; step(); ext_rx_valid = 0;
         chk_push("R9 ext rx pushed", 1'b1, {1'b0, d[7:0]});
      end
      ext_brk = 1; step(); ext_brk = 0;
      chk_push("R9 ext brk word", 1'b1, 9'h100);
      step(); chk_push("R9 idle", 1'b0, '0);

      // R10: loopback off collision and merge
      ext_rx_valid = 1; ext_rx_data = 8'hA1; ext_brk = 1; step();
      chk_push("R10 off data first", 1'b1, 9'h0A1);
      ext_rx_data = 8'hA2; step();
      chk_push("R10 off data second", 1'b1, 9'h0A2);
      ext_rx_valid = 0; ext_brk = 0; step();
      chk_push("R10 off single break", 1'b1, 9'h100);
      step(); chk_push("R10 off merged", 1'b0, '0);

      // R11: tx in the enabling write cycle follows old setting, ext rx still taken
      set_pins(4'hF);
      tx_valid = 1; tx_data = 8'h55; ext_rx_valid = 1; ext_rx_data = 8'h66;
      ctrl_write(1'b1, 4'h0);
      tx_valid = 0; ext_rx_valid = 0;
      chk_push("R11 write cycle uses old mode", 1'b1, 9'h066);
      chk("R3 enabling write maps", {28'd0, sts()}, 32'd0);

      // R3/R4: sweep all control combos with loopback on
      for (int v = 0; v < 16; v++) begin
         logic [3:0] e;
         e = {v[3], v[1], v[2], v[0]};
         ctrl_write(1'b1, v[3:0]);
         chk("R3 looped flags", {28'd0, sts()}, {28'd0, e});
         chk("R4 rebuild strobe", {31'd0, ms_rebuild}, 32'd1);
         chk("R4 set bits", {28'd0, ms_set}, {28'd0, e});
         step();
         chk("R4 strobe one cycle", {31'd0, ms_rebuild}, 32'd0);
      end

      // R5: hold with pins moving, loop on
      ctrl_write(1'b1, 4'b0101);
      set_pins(4'h0);
      repeat (SYNC + 2) step();
      chk("R5 hold vs pins", {28'd0, sts()}, {28'd0, 4'b0011});
      chk("R5 no strobe idle", {31'd0, ms_rebuild}, 32'd0);

      // R6: tx looped
      for (int d = 1; d < 256; d += 51) begin
         tx_valid = 1; tx_data = d[7:0]; step(); tx_valid = 0;
         chk_push("R6 tx looped", 1'b1, {1'b0, d[7:0]});
      end
      // R8: external inputs dropped
      ext_rx_valid = 1; ext_rx_data = 8'h77; ext_brk = 1; step();
      ext_rx_valid = 0; ext_brk = 0;
      chk_push("R8 ext dropped", 1'b0, '0);
      step(); chk_push("R8 no late break", 1'b0, '0);

      // R7: send-break edge
      send_brk = 1; step();
      chk_push("R7 rise pushes break", 1'b1, 9'h100);
      step(); chk_push("R7 held level no push", 1'b0, '0);
      send_brk = 0; step(); chk_push("R7 fall no push", 1'b0, '0);

      // R10: loop on collision and merge
      send_brk = 1; tx_valid = 1; tx_data = 8'hC3; step();
      chk_push("R10 on data first", 1'b1, 9'h0C3);
      tx_data = 8'hC4; step();
      chk_push("R10 on data second", 1'b1, 9'h0C4);
      tx_valid = 0; step();
      chk_push("R10 on break after", 1'b1, 9'h100);
      step(); chk_push("R10 on single break", 1'b0, '0);
      send_brk = 0; step();

      // R5: write with loop disabled: no strobe, pins followed again
      set_pins(4'b1010);
      ctrl_write(1'b0, 4'hF);
      chk("R5 no strobe loop off write", {31'd0, ms_rebuild}, 32'd0);
      repeat (SYNC + 1) step();
      chk("R2 pins after loop off", {28'd0, sts()}, {28'd0, 4'b1010});
      tx_valid = 1; tx_data = 8'h11; step(); tx_valid = 0;
      chk_push("R9 tx ignored after loop off", 1'b0, '0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule